// File: doc/BRIEF.md
# Memory-Mapped Pin Port with Interrupt Sensing

This block is a 32-pin general-purpose I/O port controlled through a plain word-wide register read/write bus. Each pin is set up either as a general pin or as an interrupt source. A general pin is an input, or an output driven from a stored output value. An interrupt-source pin is sensed with a selectable polarity and with either level or edge triggering. Every pin input first passes through a two-stage synchroniser. The synchronised value feeds both the readable input register and the detection logic.

Software reads per-pin pending status with masked pins removed. It masks pins through one register and unmasks them through another. It clears latched edge events by writing ones to a clear register. One interrupt output is high while any unmasked pin is pending. The output value register can be loaded before the direction is flipped, so a pin starts driving at the intended level.

Register byte offsets, decoded on `bus_addr`: 0x00 mode, 0x04 direction, 0x08 output value, 0x0C input level (read only), 0x10 status (read only), 0x14 event clear (write only, reads 0), 0x18 mask, 0x1C unmask (write only, reads 0), 0x20 polarity, 0x24 trigger, 0x28 filter enable.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the mode, direction, output value, polarity, trigger and filter registers read 0. The mask register reads all ones. Status reads 0, `irq` is low and `pin_oe` is 0.
- R2: The mode (0x00), direction (0x04), output value (0x08), polarity (0x20), trigger (0x24) and filter (0x28) registers read back exactly what was last written. The filter value has no effect on the pins, on status or on `irq`.
- R3: `pin_out` equals the output value register. A `pin_oe` bit is 1 only when the pin's mode bit is 0 and its direction bit is 1. Writing the output value while the direction is 0 leaves `pin_oe` at 0.
- R4: Reading 0x0C returns `pin_in` delayed by two clock edges through the synchroniser.
- R5: With a mode bit of 1 and a trigger bit of 0 (level), the pin is pending while its synchronised input XOR its polarity bit is 1. This status is not latched, and writes to 0x14 do not affect it.
- R6: With a mode bit of 1 and a trigger bit of 1 (edge), a sticky event bit is set on a rising synchronised edge when polarity is 0, or on a falling edge when polarity is 1. The bit stays set after the input returns.
- R7: Writing 1 to a bit of 0x14 clears that pin's event bit, and a 0 bit leaves it unchanged. If an edge is detected in the same cycle as the clear write, the bit stays set.
- R8: A write to 0x18 sets the mask bit of every pin whose written bit is 0 and leaves the other mask bits unchanged. A write of 1 to a bit of 0x1C clears that mask bit.
- R9: Reading 0x10 returns the pending bits AND NOT mask. `irq` is 1 exactly when that value is nonzero.
- R10: A pin whose mode bit is 0 never shows as pending, whatever its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pin input levels (asynchronous) |
| pin_out | output | 32 | Values driven on output pins |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Random rounds draw the mode, polarity, trigger, direction and mask for all 32 pins, then move the pins from one random level to another. Each round therefore tests level and edge sensing, both polarities and general-mode pins side by side. An error in one pin's class does not cancel out against another pin. Partial clears with random bit patterns check that event bits are removed while level bits are not. Directed cases cover the reset values, the edge arriving in the same cycle as its clear, a zero-bit clear, loading the output value before the direction, and filter writes that must change nothing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_MODE   = 6'h00;
    localparam logic [ADDR_W-1:0] A_DIR    = 6'h04;
    localparam logic [ADDR_W-1:0] A_DOUT   = 6'h08;
    localparam logic [ADDR_W-1:0] A_DIN    = 6'h0C;
    localparam logic [ADDR_W-1:0] A_STAT   = 6'h10;
    localparam logic [ADDR_W-1:0] A_CLR    = 6'h14;
    localparam logic [ADDR_W-1:0] A_MASK   = 6'h18;
    localparam logic [ADDR_W-1:0] A_UNMASK = 6'h1C;
    localparam logic [ADDR_W-1:0] A_POL    = 6'h20;
    localparam logic [ADDR_W-1:0] A_TRIG   = 6'h24;
    localparam logic [ADDR_W-1:0] A_FILT   = 6'h28;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] hold_q, hold_d;

    always_comb begin
        meta_d = async_in;
        hold_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= meta_d;
            hold_q <= hold_d;
        end
    end

    assign sync_out = hold_q;

    // R4: second stage follows the first one cycle later
    p_stage_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> hold_q == $past(meta_q));
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] trig,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pending
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] evt;
    } det_t;

    det_t st_q, st_d;
    logic [W-1:0] act_now, act_old, hit;

    always_comb begin
        act_now = lvl ^ pol;
        act_old = st_q.prev ^ pol;
        hit     = mode & trig & act_now & ~act_old;
        st_d.prev = lvl;
        st_d.evt  = (st_q.evt & ~clr) | hit;
        pending   = mode & ((trig & st_q.evt) | (~trig & act_now));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a detected edge is held in the event register next cycle
    p_edge_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        |hit |=> (st_q.evt & $past(hit)) == $past(hit));
    // R7: cleared bits without a coincident edge are gone next cycle
    p_clear_works_r7: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr & ~hit) |=> (st_q.evt & $past(clr & ~hit)) == '0);
    // R10: general-mode pins never pend
    p_general_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~mode) == '0);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] trig;
        logic [NPINS-1:0] filt;
    } cfg_t;

    cfg_t cfg_q, cfg_d;
    logic [NPINS-1:0] lvl_sync, pending, clr_bits, visible;

    gpio_sync #(.W(NPINS)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl_sync)
    );

    gpio_detect #(.W(NPINS)) det_i (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .mode(cfg_q.mode),
        .pol(cfg_q.pol), .trig(cfg_q.trig), .clr(clr_bits), .pending(pending)
    );

    always_comb begin
        cfg_d    = cfg_q;
        clr_bits = '0;
        if (bus_we) begin
            unique case (bus_addr)
                A_MODE:   cfg_d.mode = bus_wdata;
                A_DIR:    cfg_d.dir  = bus_wdata;
                A_DOUT:   cfg_d.dout = bus_wdata;
                A_POL:    cfg_d.pol  = bus_wdata;
                A_TRIG:   cfg_d.trig = bus_wdata;
                A_FILT:   cfg_d.filt = bus_wdata;
                A_MASK:   cfg_d.mask = cfg_q.mask | ~bus_wdata;
                A_UNMASK: cfg_d.mask = cfg_q.mask & ~bus_wdata;
                A_CLR:    clr_bits   = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.mask <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        visible = pending & ~cfg_q.mask;
        unique case (bus_addr)
            A_MODE:  bus_rdata = cfg_q.mode;
            A_DIR:   bus_rdata = cfg_q.dir;
            A_DOUT:  bus_rdata = cfg_q.dout;
            A_DIN:   bus_rdata = lvl_sync;
            A_STAT:  bus_rdata = visible;
            A_MASK:  bus_rdata = cfg_q.mask;
            A_POL:   bus_rdata = cfg_q.pol;
            A_TRIG:  bus_rdata = cfg_q.trig;
            A_FILT:  bus_rdata = cfg_q.filt;
            default: bus_rdata = '0;
        endcase
    end

    assign pin_out = cfg_q.dout;
    assign pin_oe  = cfg_q.dir & ~cfg_q.mode;
    assign irq     = |visible;

    // R8: zero bits written to the mask register are masked afterwards
    p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MASK) |=> (cfg_q.mask & ~$past(bus_wdata)) == ~$past(bus_wdata));
    // R8: one bits written to the unmask register are unmasked afterwards
    p_unmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_UNMASK) |=> (cfg_q.mask & $past(bus_wdata)) == '0);
    // R3: an interrupt-mode pin is never driven
    p_no_drive_irq_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & cfg_q.mode) == '0);
    // R9: a fully masked port never raises irq
    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&cfg_q.mask) |-> !irq);
endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
    import gpio_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [N-1:0]      bus_wdata = '0;
    logic [N-1:0]      bus_rdata;
    logic [N-1:0]      pin_in = '0;
    logic [N-1:0]      pin_out, pin_oe;
    logic              irq;

    int n_checks = 0;
    int n_errs = 0;
    bit done = 1'b0;

    logic [N-1:0] m_mode, m_dir, m_dout, m_pol, m_trig, m_mask, m_evt, m_pins;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [N-1:0] exp_pend(input logic [N-1:0] pins, mode, pol, trig, evt);
        return mode & ((trig & evt) | (~trig & (pins ^ pol)));
    endfunction

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic check_status(input string tag);
        logic [N-1:0] v, e;
        e = exp_pend(m_pins, m_mode, m_pol, m_trig, m_evt) & ~m_mask;
        rd(A_STAT, v);
        check(tag, v, e);
        check({tag, " irq"}, {31'b0, irq}, {31'b0, |e});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        logic [N-1:0] v, nxt, c, w;
        void'($urandom(32'd5150));
        m_mode = '0; m_dir = '0; m_dout = '0; m_pol = '0; m_trig = '0;
        m_mask = '1; m_evt = '0; m_pins = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_MODE, v); check("R1 mode", v, '0);
        rd(A_DIR, v);  check("R1 dir", v, '0);
        rd(A_DOUT, v); check("R1 dout", v, '0);
        rd(A_MASK, v); check("R1 mask", v, '1);
        rd(A_FILT, v); check("R1 filt", v, '0);
        rd(A_STAT, v); check("R1 status", v, '0);
        check("R1 irq", {31'b0, irq}, '0);
        check("R1 oe", pin_oe, '0);

        // R3 output value before direction
        wr(A_DOUT, 32'hA5A5_0F0F); m_dout = 32'hA5A5_0F0F;
        check("R3 out before dir", pin_out, m_dout);
        check("R3 oe still off", pin_oe, '0);
        wr(A_DIR, 32'h0000_FFFF); m_dir = 32'h0000_FFFF;
        check("R3 oe on", pin_oe, 32'h0000_FFFF);

        // R4 synchroniser delay
        @(negedge clk); pin_in = 32'hDEAD_BEEF;
        @(posedge clk); #1; rd(A_DIN, v); check("R4 one edge", v, '0);
        @(posedge clk); #1; rd(A_DIN, v); check("R4 two edges", v, 32'hDEAD_BEEF);
        @(negedge clk); m_pins = pin_in;

        // R2 filter writes change nothing
        wr(A_FILT, 32'h1234_5678);
        rd(A_FILT, v); check("R2 filt readback", v, 32'h1234_5678);
        check("R2 filt no oe effect", pin_oe, m_dir & ~m_mode);
        check_status("R2 filt no status effect");

        // R10 general-mode pins never pend
        wr(A_UNMASK, '1); m_mask = '0;
        @(negedge clk); pin_in = ~pin_in; m_pins = pin_in;
        settle();
        check_status("R10 general quiet");

        // R6/R7 edge with same-cycle clear, zero-bit clear, real clear
        wr(A_TRIG, 32'h1); m_trig = 32'h1;
        wr(A_POL, 32'h0);
        wr(A_MODE, 32'h1); m_mode = 32'h1;
        @(negedge clk); pin_in[0] = 1'b0; m_pins = pin_in;
        settle();
        wr(A_CLR, '1); m_evt = '0;
        check_status("R7 clean start");
        @(negedge clk); pin_in[0] = 1'b1; m_pins = pin_in;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_addr = A_CLR; bus_wdata = 32'h1; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        m_evt = 32'h1;
        check_status("R7 set wins over clear");
        wr(A_CLR, 32'hFFFF_FFFE);
        check_status("R7 zero bit keeps");
        @(negedge clk); pin_in[0] = 1'b0; m_pins = pin_in; settle();
        check_status("R6 sticky after return");
        wr(A_CLR, 32'h1); m_evt = '0;
        check_status("R7 clear one bit");

        // random rounds: R2 R5 R6 R7 R8 R9 R10 R3
        for (int it = 0; it < 60; it++) begin
            m_mode = $urandom; m_pol = $urandom; m_trig = $urandom;
            m_dir = $urandom; m_dout = $urandom;
            wr(A_MODE, m_mode); wr(A_POL, m_pol); wr(A_TRIG, m_trig);
            wr(A_DIR, m_dir); wr(A_DOUT, m_dout);
            rd(A_POL, v);  check("R2 pol readback", v, m_pol);
            rd(A_TRIG, v); check("R2 trig readback", v, m_trig);
            rd(A_MODE, v); check("R2 mode readback", v, m_mode);
            check("R3 oe", pin_oe, m_dir & ~m_mode);
            check("R3 out", pin_out, m_dout);
            settle();
            wr(A_CLR, '1); m_evt = '0;
            nxt = $urandom;
            @(negedge clk); pin_in = nxt;
            settle();
            m_evt = m_mode & m_trig & (m_pol ? '0 : '0);
            m_evt = m_mode & m_trig & ((~m_pins & nxt & ~m_pol) | (m_pins & ~nxt & m_pol));
            m_pins = nxt;
            rd(A_DIN, v); check("R4 din", v, m_pins);
            w = $urandom; c = $urandom;
            wr(A_MASK, w);   m_mask = m_mask | ~w;
            wr(A_UNMASK, c); m_mask = m_mask & ~c;
            rd(A_MASK, v); check("R8 mask", v, m_mask);
            check_status("R9 R6 R5 status");
            c = $urandom;
            wr(A_CLR, c); m_evt = m_evt & ~c;
            check_status("R5 R7 after partial clear");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule